// File: doc/BRIEF.md
# Virtual machine entry sequencer

This block tracks whether a processor core has switched on hardware virtualization, whether it is currently running a guest, and the launch state of the control structure that is currently loaded. Each command (switch on, first entry, re-entry, structure clear, structure load) arrives on a valid/ready port. The block returns exactly one response for each command, one cycle after it is accepted. The response gives a result code and, where relevant, an error number. After a response the block holds a 32-bit exit-reason word.

The core's preconditions arrive as plain input levels: the mode-enable control bit, the three-bit feature-control field, the privilege level, MOV-SS blocking, and whether shadow structures are allowed. The three entry check phases are not computed here. Their pass/fail results arrive as three flags. Guest execution is modelled only by the rule that any command issued in guest mode causes an exit back to the hypervisor.

A single slot remembers one structure pointer and its launch state. A pointer that is not held in that slot is treated as clear.

Top module: `vmentry_seq`

## Requirements
- R1: After reset the block is out of virtualization mode and not in guest mode. `cmd_ready` is 1, `rsp_valid` is 0, `err_num` and `exit_reason` are 0, `cur_ptr` is all ones and `cur_launched` is 0.
- R2: Command opcodes are enable 0, launch 1, resume 2, clear 3 and load 4; opcodes 5 to 7 are undefined. Result codes are OK 0, invalid-opcode 1, general-protection 2, fail-valid 3, entry-failure exit 4 and guest exit 5. An undefined opcode returns code 1. Out of virtualization mode, every command except enable returns code 1, and so does enable when `mode_en` is 0.
- R3: With `mode_en` set, enable returns code 2 if `priv` is not 0, or if `feat_ctl` bit 0 (lock) or bit 2 (permit) is clear. Bit 1 is ignored.
- R4: A successful enable returns code 0, sets `in_vmx` and sets `cur_ptr` to all ones. Enable issued while already in virtualization mode returns fail-valid with error 7.
- R5: In root mode, clear and load at nonzero `priv` return code 2. Clear makes the given pointer's launch state clear, and sets `cur_ptr` to all ones if that pointer was current. Load makes the pointer current without changing the launch state held for it; a pointer not held in the slot starts as clear.
- R6: Launch is legal only when the current structure is clear, and on full success it makes it launched. Resume is legal only when it is launched. A wrong pairing returns fail-valid with error 1 (launch on launched) or error 2 (resume on clear).
- R7: Launch and resume return code 2 when `priv` is not 0. They return fail-valid with error 5 when no structure is current, and error 6 under MOV-SS blocking. The checks are applied in that order, and all of them come before the launch-state check.
- R8: A failed phase 1 returns fail-valid with error 3. The block stays in root mode, and the launch state and `exit_reason` are unchanged. If all three phases pass, the command returns code 0 and the block enters guest mode.
- R9: A failed phase 2 returns code 4 with `exit_reason` = 0x80000021. A failed phase 3 (phase 2 passed) returns code 4 with 0x80000022. The block stays in root mode and the launch state is unchanged.
- R10: Load returns fail-valid with error 4, and leaves `cur_ptr` unchanged, when `cmd_shadow` (bit 31 of the structure's revision word) is set and `shadow_en` is 0.
- R11: Any defined command issued in guest mode does not execute. It returns code 5, leaves guest mode and sets `exit_reason` to a basic reason with bit 31 clear: enable 27, launch 20, resume 24, clear 19, load 21.
- R12: `rsp_valid` pulses for one cycle, in the cycle after acceptance, and `cmd_ready` is low during that cycle. `err_num` holds the error of the last fail-valid response and becomes 0 when any other response completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_op | input | 3 | Command opcode |
| cmd_ptr | input | PTR_W | Structure pointer for clear and load |
| cmd_shadow | input | 1 | Shadow indicator of the structure being loaded |
| mode_en | input | 1 | Mode-enable control bit |
| feat_ctl | input | 3 | Feature-control field (bit 0 lock, bit 2 permit) |
| priv | input | 2 | Current privilege level |
| movss_blk | input | 1 | MOV-SS blocking active |
| shadow_en | input | 1 | Shadow structures allowed |
| chk1_ok | input | 1 | Phase 1 (controls, host state) passed |
| chk2_ok | input | 1 | Phase 2 (guest state) passed |
| chk3_ok | input | 1 | Phase 3 (MSR-load list) passed |
| rsp_valid | output | 1 | Response pulse |
| rsp_code | output | 3 | Result code |
| err_num | output | ERR_W | Last fail-valid error number |
| exit_reason | output | 32 | Exit-reason word |
| in_vmx | output | 1 | Virtualization mode on |
| in_guest | output | 1 | Guest (non-root) mode |
| cur_ptr | output | PTR_W | Current structure pointer, all ones when none |
| cur_launched | output | 1 | Current structure is launched |

## Verification
The hardest situations to reach are the ones that depend on history: resume on a clear structure, launch on a launched one, and phase failures that must leave the launch state untouched. Each of these needs a particular sequence of earlier entries and exits. The bench sweeps every combination of privilege, MOV-SS blocking and the three phase flags for both entry commands. It runs each combination with and without first re-clearing the structure, and uses a guest-mode command to exit after every successful entry. A small model of the launch state and exit reason gives the expected values.

// File: rtl/vmentry_seq.sv
module vmentry_seq #(
  parameter int PTR_W = 16,
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [PTR_W-1:0] cmd_ptr,
  input  logic             cmd_shadow,
  input  logic             mode_en,
  input  logic [2:0]       feat_ctl,
  input  logic [1:0]       priv,
  input  logic             movss_blk,
  input  logic             shadow_en,
  input  logic             chk1_ok,
  input  logic             chk2_ok,
  input  logic             chk3_ok,
  output logic             rsp_valid,
  output logic [2:0]       rsp_code,
  output logic [ERR_W-1:0] err_num,
  output logic [31:0]      exit_reason,
  output logic             in_vmx,
  output logic             in_guest,
  output logic [PTR_W-1:0] cur_ptr,
  output logic             cur_launched
);
  localparam logic [2:0] OP_EN = 3'd0, OP_LA = 3'd1, OP_RS = 3'd2, OP_CL = 3'd3, OP_LD = 3'd4;
  localparam logic [2:0] RC_OK = 3'd0, RC_UD = 3'd1, RC_GP = 3'd2, RC_FV = 3'd3, RC_EF = 3'd4, RC_GX = 3'd5;
  localparam logic [ERR_W-1:0] E_LAUNCHED = ERR_W'(1), E_CLEAR = ERR_W'(2), E_PH1 = ERR_W'(3),
                               E_SHADOW = ERR_W'(4), E_NOCUR = ERR_W'(5), E_MOVSS = ERR_W'(6),
                               E_ON = ERR_W'(7);
  localparam logic [PTR_W-1:0] NO_PTR = '1;

  logic             vmx_q, guest_q, rsp_q, slot_l_q;
  logic [2:0]       code_q;
  logic [ERR_W-1:0] err_q;
  logic [31:0]      rsn_q;
  logic [PTR_W-1:0] cur_q, slot_q;

  logic             d_vmx, d_guest, d_sl;
  logic [2:0]       d_code;
  logic [ERR_W-1:0] d_err;
  logic [31:0]      d_rsn;
  logic [PTR_W-1:0] d_cur, d_slot;
  logic             accept, launched, feat_ok;
  logic [15:0]      basic;

  assign accept       = cmd_valid && !rsp_q;
  assign launched     = (cur_q != NO_PTR) && (cur_q == slot_q) && slot_l_q;
  assign feat_ok      = (feat_ctl | 3'b010) == 3'b111;
  assign cmd_ready    = !rsp_q;
  assign rsp_valid    = rsp_q;
  assign rsp_code     = code_q;
  assign err_num      = err_q;
  assign exit_reason  = rsn_q;
  assign in_vmx       = vmx_q;
  assign in_guest     = guest_q;
  assign cur_ptr      = cur_q;
  assign cur_launched = launched;

  always_comb begin
    case (cmd_op)
      OP_EN:   basic = 16'd27;
      OP_LA:   basic = 16'd20;
      OP_RS:   basic = 16'd24;
      OP_CL:   basic = 16'd19;
      default: basic = 16'd21;
    endcase
  end

  always_comb begin
    d_code  = RC_OK;
    d_err   = '0;
    d_rsn   = rsn_q;
    d_vmx   = vmx_q;
    d_guest = guest_q;
    d_cur   = cur_q;
    d_slot  = slot_q;
    d_sl    = slot_l_q;
    if (cmd_op > OP_LD) begin
      d_code = RC_UD;
    end else if (guest_q) begin
      d_code  = RC_GX;
      d_guest = 1'b0;
      d_rsn   = {16'h0000, basic};
    end else if (!vmx_q) begin
      if (cmd_op != OP_EN || !mode_en) d_code = RC_UD;
      else if (priv != 2'd0 || !feat_ok) d_code = RC_GP;
      else begin
        d_vmx = 1'b1;
        d_cur = NO_PTR;
      end
    end else if (priv != 2'd0) begin
      d_code = RC_GP;
    end else begin
      case (cmd_op)
        OP_EN: begin
          d_code = RC_FV;
          d_err  = E_ON;
        end
        OP_CL: begin
          d_slot = cmd_ptr;
          d_sl   = 1'b0;
          if (cmd_ptr == cur_q) d_cur = NO_PTR;
        end
        OP_LD: begin
          if (cmd_shadow && !shadow_en) begin
            d_code = RC_FV;
            d_err  = E_SHADOW;
          end else begin
            d_cur = cmd_ptr;
            if (cmd_ptr != slot_q) begin
              d_slot = cmd_ptr;
              d_sl   = 1'b0;
            end
          end
        end
        default: begin
          if (cur_q == NO_PTR) begin
            d_code = RC_FV;
            d_err  = E_NOCUR;
          end else if (movss_blk) begin
            d_code = RC_FV;
            d_err  = E_MOVSS;
          end else if (cmd_op == OP_LA && launched) begin
            d_code = RC_FV;
            d_err  = E_LAUNCHED;
          end else if (cmd_op == OP_RS && !launched) begin
            d_code = RC_FV;
            d_err  = E_CLEAR;
          end else if (!chk1_ok) begin
            d_code = RC_FV;
            d_err  = E_PH1;
          end else if (!chk2_ok) begin
            d_code = RC_EF;
            d_rsn  = 32'h8000_0021;
          end else if (!chk3_ok) begin
            d_code = RC_EF;
            d_rsn  = 32'h8000_0022;
          end else begin
            d_guest = 1'b1;
            d_slot  = cur_q;
            d_sl    = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q    <= 1'b0;
      code_q   <= RC_OK;
      err_q    <= '0;
      rsn_q    <= '0;
      vmx_q    <= 1'b0;
      guest_q  <= 1'b0;
      cur_q    <= NO_PTR;
      slot_q   <= NO_PTR;
      slot_l_q <= 1'b0;
    end else begin
      rsp_q <= accept;
      if (accept) begin
        code_q   <= d_code;
        err_q    <= d_err;
        rsn_q    <= d_rsn;
        vmx_q    <= d_vmx;
        guest_q  <= d_guest;
        cur_q    <= d_cur;
        slot_q   <= d_slot;
        slot_l_q <= d_sl;
      end
    end
  end
endmodule

// File: rtl/vmentry_seq_chk.sv
module vmentry_seq_chk #(
  parameter int PTR_W = 16,
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             rsp_valid,
  input logic [2:0]       rsp_code,
  input logic [ERR_W-1:0] err_num,
  input logic [31:0]      exit_reason,
  input logic             in_vmx,
  input logic             in_guest,
  input logic [PTR_W-1:0] cur_ptr
);
  a_r12_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> rsp_valid);
  a_r12_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready);
  a_r12_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code != 3'd3) |-> (err_num == '0));
  a_r4_no_current: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_vmx) |-> (rsp_code == 3'd0 && cur_ptr == '1));
  a_r8_enter_ok: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_guest) |-> (rsp_valid && rsp_code == 3'd0));
  a_r9_fail_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 3'd4) |-> (exit_reason[31] && !in_guest));
  a_r11_guest_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_guest) |-> (rsp_valid && rsp_code == 3'd5 && !exit_reason[31]));
  a_r2_guest_needs_vmx: assert property (@(posedge clk) disable iff (!rst_n)
    in_guest |-> in_vmx);
endmodule

bind vmentry_seq vmentry_seq_chk #(.PTR_W(PTR_W), .ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid), .rsp_code(rsp_code), .err_num(err_num),
  .exit_reason(exit_reason), .in_vmx(in_vmx), .in_guest(in_guest), .cur_ptr(cur_ptr)
);

// File: tb/test_vmentry_seq.sv
module test_vmentry_seq;
  localparam int PTR_W = 16, ERR_W = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_shadow = 1'b0, mode_en = 1'b1, movss_blk = 1'b0, shadow_en = 1'b0;
  logic chk1_ok = 1'b1, chk2_ok = 1'b1, chk3_ok = 1'b1;
  logic [2:0] cmd_op = '0, feat_ctl = 3'b101;
  logic [1:0] priv = '0;
  logic [PTR_W-1:0] cmd_ptr = '0;
  logic cmd_ready, rsp_valid, in_vmx, in_guest, cur_launched;
  logic [2:0] rsp_code;
  logic [ERR_W-1:0] err_num;
  logic [31:0] exit_reason;
  logic [PTR_W-1:0] cur_ptr;
  int n_cmp = 0, n_bad = 0;
  logic [31:0] m_rsn;
  logic m_l;

  always #10 clk = ~clk;

  vmentry_seq #(.PTR_W(PTR_W), .ERR_W(ERR_W)) i_vmentry_seq (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic issue(logic [2:0] op, logic [PTR_W-1:0] p);
    @(negedge clk);
    cmd_op = op; cmd_ptr = p; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic resp(string tag, logic [2:0] c, logic [7:0] e);
    chk({tag, " rsp_valid"}, 32'(rsp_valid), 1);
    chk({tag, " ready"}, 32'(cmd_ready), 0);
    chk({tag, " code"}, 32'(rsp_code), 32'(c));
    chk({tag, " err"}, 32'(err_num), 32'(e));
  endtask

  task automatic enable_ok();
    priv = 0; mode_en = 1; feat_ctl = 3'b101;
    issue(3'd0, '0);
    resp("R4 enable", 3'd0, 8'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1
    chk("R1 in_vmx", 32'(in_vmx), 0);
    chk("R1 in_guest", 32'(in_guest), 0);
    chk("R1 ready", 32'(cmd_ready), 1);
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    chk("R1 err", 32'(err_num), 0);
    chk("R1 reason", exit_reason, 0);
    chk("R1 cur_ptr", 32'(cur_ptr), 32'hFFFF);
    chk("R1 launched", 32'(cur_launched), 0);

    // R2: every non-enable opcode out of mode
    for (int o = 1; o < 8; o++) begin
      issue(3'(o), '0);
      resp("R2 off-mode op", 3'd1, 8'd0);
    end

    // R2 R3 R4: enable sweep
    for (int c = 0; c < 64; c++) begin
      logic [2:0] ec;
      do_reset();
      mode_en = c[0]; feat_ctl = c[3:1]; priv = c[5:4];
      if (!c[0]) ec = 3'd1;
      else if (c[5:4] != 0 || !c[1] || !c[3]) ec = 3'd2;
      else ec = 3'd0;
      issue(3'd0, '0);
      resp("R3 enable sweep", ec, 8'd0);
      chk("R4 in_vmx", 32'(in_vmx), 32'(ec == 3'd0));
      chk("R4 cur_ptr", 32'(cur_ptr), 32'hFFFF);
    end

    do_reset();
    enable_ok();
    issue(3'd0, '0);
    resp("R4 enable twice", 3'd3, 8'd7);
    issue(3'd6, '0);
    resp("R2 undefined op", 3'd1, 8'd0);
    @(negedge clk);
    chk("R12 ready back", 32'(cmd_ready), 1);
    chk("R12 one pulse", 32'(rsp_valid), 0);

    // R7: no current structure
    issue(3'd1, '0);
    resp("R7 no current", 3'd3, 8'd5);
    @(negedge clk);
    chk("R12 err held", 32'(err_num), 5);

    // R10 shadow
    cmd_shadow = 1; shadow_en = 0;
    issue(3'd4, 16'd5);
    resp("R10 shadow reject", 3'd3, 8'd4);
    chk("R10 cur unchanged", 32'(cur_ptr), 32'hFFFF);
    shadow_en = 1;
    issue(3'd4, 16'd5);
    resp("R10 shadow allowed", 3'd0, 8'd0);
    chk("R10 cur", 32'(cur_ptr), 5);
    cmd_shadow = 0; shadow_en = 0;

    // R5 privilege
    priv = 2'd3;
    issue(3'd3, 16'd5);
    resp("R5 clear gp", 3'd2, 8'd0);
    issue(3'd4, 16'd5);
    resp("R5 load gp", 3'd2, 8'd0);
    priv = 0;

    // R6 R7 R8 R9 R11: entry sweep with launch state model
    m_l = 1'b0;
    m_rsn = 32'h0;
    for (int c = 0; c < 64; c++) begin
      for (int o = 0; o < 4; o++) begin
        logic [2:0] op, ec;
        logic [7:0] ee;
        logic go;
        if (o[1]) begin
          priv = 0;
          issue(3'd3, 16'd5);
          resp("R5 clear", 3'd0, 8'd0);
          chk("R5 clear drops current", 32'(cur_ptr), 32'hFFFF);
          issue(3'd4, 16'd5);
          resp("R5 load", 3'd0, 8'd0);
          chk("R5 load clear", 32'(cur_launched), 0);
          m_l = 0;
        end
        op = o[0] ? 3'd2 : 3'd1;
        priv = c[1:0]; movss_blk = c[2]; chk1_ok = c[3]; chk2_ok = c[4]; chk3_ok = c[5];
        go = 0; ee = 0;
        if (c[1:0] != 0) ec = 3'd2;
        else if (c[2]) begin ec = 3'd3; ee = 6; end
        else if (op == 3'd1 && m_l) begin ec = 3'd3; ee = 1; end
        else if (op == 3'd2 && !m_l) begin ec = 3'd3; ee = 2; end
        else if (!c[3]) begin ec = 3'd3; ee = 3; end
        else if (!c[4]) begin ec = 3'd4; m_rsn = 32'h8000_0021; end
        else if (!c[5]) begin ec = 3'd4; m_rsn = 32'h8000_0022; end
        else begin ec = 3'd0; go = 1; m_l = 1; end
        issue(op, 16'd5);
        resp("R6 entry sweep", ec, ee);
        chk("R9 reason", exit_reason, m_rsn);
        chk("R8 guest", 32'(in_guest), 32'(go));
        chk("R8 launch state", 32'(cur_launched), 32'(m_l));
        if (go) begin
          issue(3'd4, 16'd5);
          m_rsn = 32'd21;
          resp("R11 exit", 3'd5, 8'd0);
          chk("R11 reason", exit_reason, m_rsn);
          chk("R11 root", 32'(in_guest), 0);
          chk("R11 not executed", 32'(cur_ptr), 5);
        end
      end
    end
    priv = 0; movss_blk = 0; chk1_ok = 1; chk2_ok = 1; chk3_ok = 1;

    // R11 per-opcode basic reasons
    for (int o = 0; o < 5; o++) begin
      logic [31:0] br;
      issue(m_l ? 3'd2 : 3'd1, 16'd5);
      resp("R8 enter", 3'd0, 8'd0);
      m_l = 1;
      br = (o == 0) ? 27 : (o == 1) ? 20 : (o == 2) ? 24 : (o == 3) ? 19 : 21;
      issue(3'(o), 16'd9);
      resp("R11 op exit", 3'd5, 8'd0);
      chk("R11 op reason", exit_reason, br);
    end

    // R5 load of another pointer and back: single slot keeps state
    issue(3'd4, 16'd5);
    resp("R5 reload same", 3'd0, 8'd0);
    chk("R5 keeps launched", 32'(cur_launched), 1);
    issue(3'd4, 16'd7);
    resp("R5 load other", 3'd0, 8'd0);
    chk("R5 other is clear", 32'(cur_launched), 0);
    issue(3'd2, 16'd7);
    resp("R6 resume clear", 3'd3, 8'd2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule